// File: doc/BRIEF.md
# Run-Test Signature and Pattern Engine

This block computes the run-test step for a boundary register that has eight data-input cells and eight output cells. A two-bit mode register chooses one of four operations: sampling the pins while the outputs toggle, 16-bit pattern generation, 16-bit signature compression, or an 8-bit signature on the input half with 8-bit pattern generation on the output half at the same time. The mode register is loaded through the test serial path. It is selected by the instruction decode, shifted while the controller is in the shift-data state, and made active on the falling edge of the test clock while the controller is in the update-data state.

The surrounding boundary register supplies the current contents of its shift stages and the pin data. The engine returns the next shift-stage values and a step strobe, which the register applies on the rising edge. It also returns two registered enables that tell the register which shadow latches to copy on the following falling edge. A separate toggle-outputs instruction inverts the output cells and leaves the input cells alone. The two control cells of the boundary register (latch enable and output enable) are not connected here.

Top module: `runtest_engine`

## Requirements
- R1: After `rst_n` goes low, or at any clock where `tlr` is high, both the mode shift stage and the active mode return to code 2'b10, so that `ctl_tdo` reads 0 and a step runs signature compression.
- R2: With `ctl_sel` and `shift_dr` high, each rising edge shifts `tdi` into mode bit 1 and bit 1 into bit 0. `ctl_tdo` shows bit 0. The active mode takes the shifted value on a falling edge only while `ctl_sel` and `update_dr` are high, and it is unchanged when `ctl_sel` is low.
- R3: Mode 2'b00: `next_in` equals `pin_d` and `next_out` equals the inverse of `out_cells`.
- R4: Mode 2'b01: let V = {in_cells, out_cells} (in_cells[7] is bit 15). The next V is {V[14:0], V[15]^V[11]^V[2]^V[0]}, and the pins are ignored.
- R5: Mode 2'b10: the next V is the R4 result XORed with {pin_d, pin_d}.
- R6: Mode 2'b11: each half H steps independently to {H[6:0], H[7]^H[3]^H[2]^H[1]}, and `pin_d` is XORed into the input half only.
- R7: An all-zero seed stays all zero in the modes 2'b01, and in mode 2'b11 on the output half.
- R8: With `toggle_en` high (which has priority over `run_en`), `next_out` is the inverse of `out_cells`, `next_in` equals `in_cells`, and the pins are ignored.
- R9: `cell_step` is high exactly when `run_en` or `toggle_en` is high. When both are low, `next_in` and `next_out` equal the current cells.
- R10: `in_upd` and `out_upd` are registered on the step edge and remain valid until the next rising edge. Modes 2'b00, 2'b01 and 2'b11 set both. Mode 2'b10 sets only `in_upd`. Toggle sets only `out_upd`. Both are 0 after a clock without a step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| tlr | input | 1 | Controller is in Test-Logic-Reset |
| ctl_sel | input | 1 | Instruction selects the mode register for data scans |
| shift_dr | input | 1 | Controller is in Shift-DR |
| update_dr | input | 1 | Controller is in Update-DR |
| tdi | input | 1 | Serial test data in |
| run_en | input | 1 | Run-Test/Idle with the run-test instruction active |
| toggle_en | input | 1 | Run-Test/Idle with the toggle-outputs instruction active |
| pin_d | input | HALF | Data present at the input pins |
| in_cells | input | HALF | Current input-cell shift stages |
| out_cells | input | HALF | Current output-cell shift stages |
| ctl_tdo | output | 1 | Serial out of the mode register (bit 0) |
| cell_step | output | 1 | Load the next values into the shift stages on this rising edge |
| next_in | output | HALF | Next input-cell shift-stage values |
| next_out | output | HALF | Next output-cell shift-stage values |
| in_upd | output | 1 | Copy input shift stages to shadows on the coming falling edge |
| out_upd | output | 1 | Copy output shift stages to shadows on the coming falling edge |

## Verification
The bench builds the engine with its default parameters: eight cells per half and the 16-bit and 8-bit tap sets. These values let one-bit seeds that are easy to compute by hand exercise every tap position and the carry across the two halves. Each mode is loaded through the serial path before its vectors run. With those widths, a two-bit scan readback shows both the shift order and that a scan leaves the mode unchanged when the mode register is not selected.

// File: rtl/runtest_engine.sv
module runtest_engine #(
  parameter int HALF = 8,
  parameter logic [2*HALF-1:0] WIDE_TAPS = 16'h8805,
  parameter logic [HALF-1:0] HALF_TAPS = 8'h8E,
  parameter logic [1:0] CTL_INIT = 2'b10
) (
  input  logic            tck,
  input  logic            rst_n,
  input  logic            tlr,
  input  logic            ctl_sel,
  input  logic            shift_dr,
  input  logic            update_dr,
  input  logic            tdi,
  input  logic            run_en,
  input  logic            toggle_en,
  input  logic [HALF-1:0] pin_d,
  input  logic [HALF-1:0] in_cells,
  input  logic [HALF-1:0] out_cells,
  output logic            ctl_tdo,
  output logic            cell_step,
  output logic [HALF-1:0] next_in,
  output logic [HALF-1:0] next_out,
  output logic            in_upd,
  output logic            out_upd
);
  localparam int WIDE = 2 * HALF;
  localparam logic [1:0] M_SAMPLE = 2'b00;
  localparam logic [1:0] M_PRPG   = 2'b01;
  localparam logic [1:0] M_PSA    = 2'b10;

  logic [1:0] ctl_sh, ctl_q;

  always_ff @(posedge tck or negedge rst_n)
    if (!rst_n)                    ctl_sh <= CTL_INIT;
    else if (tlr)                  ctl_sh <= CTL_INIT;
    else if (ctl_sel && shift_dr)  ctl_sh <= {tdi, ctl_sh[1]};

  always_ff @(negedge tck or negedge rst_n)
    if (!rst_n)                    ctl_q <= CTL_INIT;
    else if (tlr)                  ctl_q <= CTL_INIT;
    else if (ctl_sel && update_dr) ctl_q <= ctl_sh;

  assign ctl_tdo = ctl_sh[0];

  function automatic logic [WIDE-1:0] step_wide(input logic [WIDE-1:0] v);
    return {v[WIDE-2:0], ^(v & WIDE_TAPS)};
  endfunction

  function automatic logic [HALF-1:0] step_half(input logic [HALF-1:0] v);
    return {v[HALF-2:0], ^(v & HALF_TAPS)};
  endfunction

  logic [WIDE-1:0] wide_gen;
  assign wide_gen  = step_wide({in_cells, out_cells});
  assign cell_step = run_en | toggle_en;

  logic upd_in_c, upd_out_c;

  always_comb begin
    next_in   = in_cells;
    next_out  = out_cells;
    upd_in_c  = 1'b0;
    upd_out_c = 1'b0;
    if (toggle_en) begin
      next_out  = ~out_cells;
      upd_out_c = 1'b1;
    end else if (run_en) begin
      upd_in_c  = 1'b1;
      upd_out_c = (ctl_q != M_PSA);
      case (ctl_q)
        M_SAMPLE: begin
          next_in  = pin_d;
          next_out = ~out_cells;
        end
        M_PRPG:   {next_in, next_out} = wide_gen;
        M_PSA:    {next_in, next_out} = wide_gen ^ {pin_d, pin_d};
        default: begin
          next_in  = step_half(in_cells) ^ pin_d;
          next_out = step_half(out_cells);
        end
      endcase
    end
  end

  always_ff @(posedge tck or negedge rst_n)
    if (!rst_n) begin
      in_upd  <= 1'b0;
      out_upd <= 1'b0;
    end else begin
      in_upd  <= upd_in_c;
      out_upd <= upd_out_c;
    end
endmodule

// File: rtl/runtest_engine_chk.sv
module runtest_engine_chk #(parameter int HALF = 8) (
  input logic            tck,
  input logic            rst_n,
  input logic            tlr,
  input logic            ctl_sel,
  input logic            shift_dr,
  input logic            update_dr,
  input logic            run_en,
  input logic            toggle_en,
  input logic [HALF-1:0] pin_d,
  input logic [HALF-1:0] in_cells,
  input logic [HALF-1:0] out_cells,
  input logic [HALF-1:0] next_in,
  input logic [HALF-1:0] next_out,
  input logic            in_upd,
  input logic            out_upd,
  input logic [1:0]      ctl_sh,
  input logic [1:0]      ctl_q
);
  assert_tlr_init_R1: assert property (@(posedge tck) disable iff (!rst_n)
    tlr |=> ctl_sh == 2'b10);

  assert_shift_hold_R2: assert property (@(posedge tck) disable iff (!rst_n)
    (!(ctl_sel && shift_dr) && !tlr) |=> $stable(ctl_sh));

  assert_mode_hold_R2: assert property (@(posedge tck) disable iff (!rst_n)
    (!(ctl_sel && update_dr) && !tlr) |-> $stable(ctl_q));

  assert_zero_seed_R7: assert property (@(posedge tck) disable iff (!rst_n)
    (run_en && !toggle_en && ctl_q != 2'b00 && pin_d == '0 && in_cells == '0 && out_cells == '0)
      |-> (next_in == '0 && next_out == '0));

  assert_toggle_R8: assert property (@(posedge tck) disable iff (!rst_n)
    toggle_en |-> (next_out == ~out_cells && next_in == in_cells));

  assert_idle_hold_R9: assert property (@(posedge tck) disable iff (!rst_n)
    (!run_en && !toggle_en) |-> (next_in == in_cells && next_out == out_cells));

  assert_idle_upd_R10: assert property (@(posedge tck) disable iff (!rst_n)
    (!run_en && !toggle_en) |=> (!in_upd && !out_upd));
endmodule

bind runtest_engine runtest_engine_chk #(.HALF(HALF)) chk (
  .tck(tck), .rst_n(rst_n), .tlr(tlr), .ctl_sel(ctl_sel), .shift_dr(shift_dr),
  .update_dr(update_dr), .run_en(run_en), .toggle_en(toggle_en), .pin_d(pin_d),
  .in_cells(in_cells), .out_cells(out_cells), .next_in(next_in), .next_out(next_out),
  .in_upd(in_upd), .out_upd(out_upd), .ctl_sh(ctl_sh), .ctl_q(ctl_q)
);

// File: tb/runtest_engine_test.sv
`timescale 1ns/1ps
module runtest_engine_test;
  logic tck = 0, rst_n = 0, tlr = 0, ctl_sel = 0, shift_dr = 0, update_dr = 0, tdi = 0;
  logic run_en = 0, toggle_en = 0;
  logic [7:0] pin_d = 0, in_cells = 0, out_cells = 0;
  logic ctl_tdo, cell_step, in_upd, out_upd;
  logic [7:0] next_in, next_out;
  int checks = 0, errors = 0;

  always #5 tck = ~tck;

  runtest_engine uut (.*);

  // {code, toggle, pin, in, out, exp_in, exp_out, exp_in_upd, exp_out_upd}
  localparam logic [44:0] VEC [10] = '{
    {2'b00, 1'b0, 8'h3C, 8'hFF, 8'h0F, 8'h3C, 8'hF0, 1'b1, 1'b1},
    {2'b01, 1'b0, 8'hFF, 8'h00, 8'h01, 8'h00, 8'h03, 1'b1, 1'b1},
    {2'b01, 1'b0, 8'h00, 8'h80, 8'h00, 8'h00, 8'h01, 1'b1, 1'b1},
    {2'b01, 1'b0, 8'h00, 8'h08, 8'h04, 8'h10, 8'h08, 1'b1, 1'b1},
    {2'b01, 1'b0, 8'hA5, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 1'b1},
    {2'b10, 1'b0, 8'hA5, 8'h00, 8'h00, 8'hA5, 8'hA5, 1'b1, 1'b0},
    {2'b10, 1'b0, 8'h01, 8'h80, 8'h00, 8'h01, 8'h00, 1'b1, 1'b0},
    {2'b11, 1'b0, 8'hFF, 8'h0E, 8'h00, 8'hE2, 8'h00, 1'b1, 1'b1},
    {2'b11, 1'b0, 8'h00, 8'h80, 8'h80, 8'h01, 8'h01, 1'b1, 1'b1},
    {2'b00, 1'b1, 8'hFF, 8'h55, 8'hAA, 8'h55, 8'h55, 1'b0, 1'b1}
  };

  function automatic string tag(int i);
    case (i)
      0: return "R3";
      1, 2, 3: return "R4";
      4: return "R7";
      5, 6: return "R5";
      7, 8: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic check(bit ok, string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc;
    @(posedge tck);
    #2;
  endtask

  task automatic scan_mode(logic [1:0] code);
    run_en = 0; toggle_en = 0;
    ctl_sel = 1; shift_dr = 1; tdi = code[0];
    cyc;
    tdi = code[1];
    cyc;
    shift_dr = 0; update_dr = 1;
    cyc;
    update_dr = 0; ctl_sel = 0;
  endtask

  task automatic run_psa_probe(string req);
    run_en = 1; in_cells = 8'h80; out_cells = 8'h00; pin_d = 8'h01;
    #1;
    check({next_in, next_out} == 16'h0100, req, {next_in, next_out}, 16'h0100);
    run_en = 0;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) cyc;
    rst_n = 1;
    cyc;
    check(ctl_tdo == 1'b0, "R1 reset tdo", {15'b0, ctl_tdo}, 16'h0000);
    check({in_upd, out_upd} == 2'b00, "R10 reset enables", {14'b0, in_upd, out_upd}, 16'h0000);
    run_psa_probe("R1 reset mode is signature");

    // R9: no step when idle
    in_cells = 8'h5A; out_cells = 8'hC3; pin_d = 8'hFF;
    #1;
    check(!cell_step && next_in == 8'h5A && next_out == 8'hC3, "R9 idle hold",
          {next_in, next_out}, 16'h5AC3);

    foreach (VEC[i]) begin
      logic [44:0] v;
      v = VEC[i];
      if (!v[42]) scan_mode(v[44:43]);
      pin_d = v[41:34]; in_cells = v[33:26]; out_cells = v[25:18];
      toggle_en = v[42]; run_en = !v[42];
      #1;
      check({next_in, next_out} == v[17:2], tag(i), {next_in, next_out}, v[17:2]);
      check(cell_step == 1'b1, "R9 step strobe", {15'b0, cell_step}, 16'h0001);
      cyc;
      check({in_upd, out_upd} == v[1:0], "R10 shadow enables", {14'b0, in_upd, out_upd},
            {14'b0, v[1:0]});
      run_en = 0; toggle_en = 0;
      cyc;
      check({in_upd, out_upd} == 2'b00, "R10 enables clear", {14'b0, in_upd, out_upd}, 16'h0000);
    end

    // R2: readback order and non-selected scan
    scan_mode(2'b01);
    ctl_sel = 1; shift_dr = 1; tdi = 0;
    #1;
    check(ctl_tdo == 1'b1, "R2 readback bit0", {15'b0, ctl_tdo}, 16'h0001);
    cyc;
    check(ctl_tdo == 1'b0, "R2 readback bit1", {15'b0, ctl_tdo}, 16'h0000);
    cyc;
    shift_dr = 0; update_dr = 1; ctl_sel = 0;
    cyc;
    update_dr = 0;
    run_en = 1; in_cells = 8'h00; out_cells = 8'h01; pin_d = 8'hFF;
    #1;
    check({next_in, next_out} == 16'h0003, "R2 unselected update ignored",
          {next_in, next_out}, 16'h0003);
    run_en = 0;

    // R1: Test-Logic-Reset restores the signature mode
    cyc;
    tlr = 1;
    cyc;
    tlr = 0;
    check(ctl_tdo == 1'b0, "R1 tlr tdo", {15'b0, ctl_tdo}, 16'h0000);
    run_psa_probe("R1 tlr mode is signature");

    // R8: toggle has priority over run
    scan_mode(2'b01);
    run_en = 1; toggle_en = 1; in_cells = 8'h12; out_cells = 8'h34; pin_d = 8'h00;
    #1;
    check(next_in == 8'h12 && next_out == 8'hCB, "R8 toggle priority",
          {next_in, next_out}, 16'h12CB);
    run_en = 0; toggle_en = 0;
    cyc;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule